// File: doc/BRIEF.md
# Serial Memory Page Write and Protection Controller

This block decides whether and when a write into a serial byte-addressed memory takes effect. A front-end bit shifter, which is not part of this block, decodes instruction bytes and delivers strobes: write-enable, write-data with a start address, and status-write. It then delivers each complete data byte with a valid flag, and a pulse when chip select rises. With that pulse comes a flag that tells whether the bit counter was on a byte boundary at that moment. The controller keeps the write enable latch, collects data bytes into a page buffer that wraps inside the page, and applies the commit rule when chip select rises. It then runs a self-timed write cycle of a parameterised number of clocks.

During the write cycle the buffered bytes go out on a simple memory write port, one per clock, in ascending page offset order. The busy output stays high for the whole cycle and is used to refuse array reads. The status byte stays readable throughout. It carries the status-protect enable, two block-protect bits, the write enable latch and the write-in-progress flag. The block-protect bits fence off none, the top quarter, the top half or all of the array. Status writes can be frozen by an external write-protect pin.

Top module: `eewr_ctrl`

## Requirements
- R1: The write enable latch (status bit 1) is set only when `cs_rise` arrives with `on_boundary`=1 in a chip-select period whose only content was the write-enable strobe. Any further strobe or data byte in that period, or a rise off the boundary, leaves the latch unchanged.
- R2: A write-data instruction in the same chip-select period as the write-enable strobe writes nothing, and it does not start a cycle.
- R3: Data bytes are stored starting at page offset `addr_in[4:0]` and the offset increments per byte. After offset 31 it wraps to offset 0 of the same page, and later bytes overwrite earlier ones. `mem_addr[11:5]` is always the page taken from `addr_in[11:5]`.
- R4: A page write commits only if `cs_rise` comes with `on_boundary`=1, at least one data byte was received and the latch is set. Otherwise the whole write is discarded: no cycle starts and the latch is unchanged.
- R5: A committed page write raises `busy` and status bit 0 for exactly WRITE_CYCLES clocks, starting the clock after `cs_rise`. In the first 32 clocks of the cycle, clock i pulses `mem_we` with offset i if that offset was written, giving ascending order.
- R6: The write enable latch clears on the clock on which `busy` falls.
- R7: While `busy` is high, instruction strobes, data bytes and chip-select rises have no effect on the status byte or on the memory port.
- R8: Status byte layout: bit 7 status-protect enable, bits 3:2 block protect, bit 1 latch, bit 0 write in progress, bits 6:4 zero. After reset the status byte is 0x00, `busy` is 0 and `mem_we` is 0.
- R9: Block protect 00 guards nothing; 01 guards addresses with bits [11:10]=11; 10 guards addresses with bit 11=1; 11 guards all. A page write whose page is guarded starts no cycle and clears the latch.
- R10: A status write holds exactly one data byte and commits under the R4 conditions. It loads bit 7 and bits 3:2 from that byte and runs a cycle of WRITE_CYCLES clocks with no `mem_we`, and the latch clears at the end. If status bit 7 is 1 and `wp_n` is 0, the status byte is not changed, no cycle starts and the latch is cleared. A second data byte discards the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable instruction fully received (one-clock strobe) |
| cmd_write | input | 1 | Write-data instruction and address fully received (strobe) |
| cmd_wrsr | input | 1 | Status-write instruction received (strobe) |
| addr_in | input | 12 | Start address, valid with `cmd_write` |
| byte_vld | input | 1 | A complete data byte is on `byte_in` |
| byte_in | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip select rose (strobe) |
| on_boundary | input | 1 | Bit counter was on a byte boundary at `cs_rise` |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte |
| busy | output | 1 | Write cycle in progress; array reads are refused |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The hardest state to reach from the ports is the wrap and overwrite inside a page. It shows only when the buffer is drained. The stimulus starts a write two bytes before the page end, and in a separate write sends 34 bytes, so offsets 0 and 1 are written twice and the drained order exposes which value won. Protection and the status lock are reached the same way: status writes first set the block-protect bits and the protect enable, then writes are aimed just inside and just outside each guarded region while the pin is toggled. A behavioural model in the bench predicts every output on every clock.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    SES_IDLE = 3'd0,
    SES_WEN  = 3'd1,
    SES_WDAT = 3'd2,
    SES_SDAT = 3'd3,
    SES_DEAD = 3'd4
  } ses_e;

  // Block-protect decode on the two top address bits of a page.
  function automatic logic bp_covers(input logic [1:0] bp, input logic [1:0] top);
    logic hit;
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top == 2'b11);
      2'b10:   hit = top[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  // Status-write lock: enable bit set while the pin is held low.
  function automatic logic sr_locked(input logic wpen, input logic wp_n);
    return wpen & ~wp_n;
  endfunction

endpackage

// File: rtl/eewr_session.sv
module eewr_session
  import eewr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wren,
  input  logic cmd_write,
  input  logic cmd_wrsr,
  input  logic byte_vld,
  input  logic cs_rise,
  input  logic busy,
  output ses_e ses,
  output logic sr_one,
  output logic open_page,
  output logic take_byte,
  output logic take_sr
);

  ses_e ses_q, ses_d;
  logic sr_one_q, sr_one_d;
  logic any_cmd, accept;

  assign any_cmd = cmd_wren | cmd_write | cmd_wrsr;
  assign accept  = any_cmd & (ses_q == SES_IDLE) & ~busy & ~cs_rise;

  always_comb begin
    ses_d     = ses_q;
    sr_one_d  = sr_one_q;
    open_page = 1'b0;
    take_byte = 1'b0;
    take_sr   = 1'b0;
    if (cs_rise) begin
      ses_d    = SES_IDLE;
      sr_one_d = 1'b0;
    end else if (any_cmd) begin
      if (accept) begin
        if (cmd_wren) begin
          ses_d = SES_WEN;
        end else if (cmd_write) begin
          ses_d     = SES_WDAT;
          open_page = 1'b1;
        end else begin
          ses_d    = SES_SDAT;
          sr_one_d = 1'b0;
        end
      end else begin
        ses_d = SES_DEAD;
      end
    end else if (byte_vld) begin
      case (ses_q)
        SES_WEN:  ses_d = SES_DEAD;
        SES_WDAT: take_byte = 1'b1;
        SES_SDAT: begin
          if (sr_one_q) begin
            ses_d = SES_DEAD;
          end else begin
            sr_one_d = 1'b1;
            take_sr  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ses_q    <= SES_IDLE;
      sr_one_q <= 1'b0;
    end else begin
      ses_q    <= ses_d;
      sr_one_q <= sr_one_d;
    end
  end

  assign ses    = ses_q;
  assign sr_one = sr_one_q;

endmodule

// File: rtl/eewr_pagebuf.sv
module eewr_pagebuf #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          open_page,
  input  logic [ADDR_W-1:0]             start_addr,
  input  logic                          take_byte,
  input  logic [DATA_W-1:0]             din,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_off,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
  output logic                          any_data
);

  localparam int OW  = $clog2(PAGE_BYTES);
  localparam int PGW = ADDR_W - OW;

  logic [OW-1:0]      ptr_q;
  logic [PGW-1:0]     page_q;
  logic [PAGE_BYTES-1:0] vld_q;
  logic [DATA_W-1:0]  mem_q [PAGE_BYTES];

  // Offset advance stays inside the page.
  function automatic logic [OW-1:0] wrap_next(input logic [OW-1:0] o);
    return (o == OW'(PAGE_BYTES - 1)) ? '0 : o + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      page_q <= '0;
    end else if (open_page) begin
      ptr_q  <= start_addr[OW-1:0];
      page_q <= start_addr[ADDR_W-1:OW];
    end else if (take_byte) begin
      ptr_q  <= wrap_next(ptr_q);
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = take_byte & (ptr_q == OW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        mem_q[g] <= '0;
      end else if (open_page) begin
        vld_q[g] <= 1'b0;
      end else if (hit) begin
        vld_q[g] <= 1'b1;
        mem_q[g] <= din;
      end
    end
  end

  assign rd_valid = vld_q[rd_off];
  assign rd_data  = mem_q[rd_off];
  assign page     = page_q;
  assign any_data = |vld_q;

endmodule

// File: rtl/eewr_cycle.sv
module eewr_cycle #(
  parameter int WRITE_CYCLES = 64,
  parameter int PAGE_BYTES   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_page,
  input  logic                          go_sr,
  output logic                          busy,
  output logic                          done,
  output logic                          slot_live,
  output logic [$clog2(PAGE_BYTES)-1:0] slot
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam int OW = $clog2(PAGE_BYTES);

  logic [CW-1:0] cnt_q;
  logic          busy_q, page_q;

  assign done = busy_q & (cnt_q == CW'(WRITE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      page_q <= 1'b0;
    end else if (go_page | go_sr) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      page_q <= go_page;
    end else if (done) begin
      busy_q <= 1'b0;
      page_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign slot      = cnt_q[OW-1:0];
  assign slot_live = busy_q & page_q & (cnt_q < CW'(PAGE_BYTES));

endmodule

// File: rtl/eewr_status.sv
module eewr_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       load_sr,
  input  logic [7:0] sr_byte,
  input  logic       wip,
  output logic       wel,
  output logic       wpen,
  output logic [1:0] bp,
  output logic [7:0] status
);

  logic       wel_q, wpen_q;
  logic [1:0] bp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      wpen_q <= 1'b0;
      bp_q   <= 2'b00;
    end else begin
      if (clr_wel)      wel_q <= 1'b0;
      else if (set_wel) wel_q <= 1'b1;
      if (load_sr) begin
        wpen_q <= sr_byte[7];
        bp_q   <= sr_byte[3:2];
      end
    end
  end

  assign wel    = wel_q;
  assign wpen   = wpen_q;
  assign bp     = bp_q;
  assign status = {wpen_q, 3'b000, bp_q, wel_q, wip};

endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_write,
  input  logic              cmd_wrsr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              cs_rise,
  input  logic              on_boundary,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int OW  = $clog2(PAGE_BYTES);
  localparam int PGW = ADDR_W - OW;

  ses_e           ses;
  logic           sr_one, open_page, take_byte, take_sr;
  logic           rd_valid, any_data, slot_live, cyc_done;
  logic [7:0]     rd_data, sr_hold_q;
  logic [PGW-1:0] page;
  logic [OW-1:0]  slot;
  logic           wel, wpen;
  logic [1:0]     bp;

  // Named commit events, also watched by the checker.
  logic ev_close, ev_set_wel, ev_go_page, ev_go_sr, ev_drop;
  logic page_guarded;

  eewr_session u_ses (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(cmd_wren), .cmd_write(cmd_write), .cmd_wrsr(cmd_wrsr),
    .byte_vld(byte_vld), .cs_rise(cs_rise), .busy(busy),
    .ses(ses), .sr_one(sr_one), .open_page(open_page),
    .take_byte(take_byte), .take_sr(take_sr)
  );

  eewr_pagebuf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .open_page(open_page), .start_addr(addr_in),
    .take_byte(take_byte), .din(byte_in),
    .rd_off(slot), .rd_valid(rd_valid), .rd_data(rd_data),
    .page(page), .any_data(any_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_hold_q <= '0;
    else if (take_sr) sr_hold_q <= byte_in;
  end

  assign ev_close     = cs_rise & on_boundary & ~busy;
  assign page_guarded = bp_covers(bp, page[PGW-1 -: 2]);
  assign ev_set_wel   = ev_close & (ses == SES_WEN);
  assign ev_go_page   = ev_close & (ses == SES_WDAT) & any_data & wel & ~page_guarded;
  assign ev_go_sr     = ev_close & (ses == SES_SDAT) & sr_one & wel & ~sr_locked(wpen, wp_n);
  assign ev_drop      = ev_close & wel &
                        (((ses == SES_WDAT) & any_data & page_guarded) |
                         ((ses == SES_SDAT) & sr_one & sr_locked(wpen, wp_n)));

  eewr_cycle #(.WRITE_CYCLES(WRITE_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_cyc (
    .clk(clk), .rst_n(rst_n),
    .go_page(ev_go_page), .go_sr(ev_go_sr),
    .busy(busy), .done(cyc_done), .slot_live(slot_live), .slot(slot)
  );

  eewr_status u_sts (
    .clk(clk), .rst_n(rst_n),
    .set_wel(ev_set_wel), .clr_wel(cyc_done | ev_drop),
    .load_sr(ev_go_sr), .sr_byte(sr_hold_q), .wip(busy),
    .wel(wel), .wpen(wpen), .bp(bp), .status(status)
  );

  assign mem_we    = slot_live & rd_valid;
  assign mem_addr  = {page, slot};
  assign mem_wdata = rd_data;

endmodule

// File: rtl/eewr_chk.sv
module eewr_chk
  import eewr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              on_boundary,
  input logic              wp_n,
  input logic [7:0]        status,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_set_wel
);

  p_wel_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cs_rise && on_boundary && ev_set_wel));

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:5] == $past(mem_addr[ADDR_W-1:5])));

  p_commit_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && on_boundary && status[1]));

  p_we_in_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_wel_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status[7:1]));

  p_layout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] == busy) && (status[6:4] == 3'b000));

  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !bp_covers(status[3:2], mem_addr[ADDR_W-1 -: 2]));

  p_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && status[7] && !wp_n) |=> $stable(status[7:2]));

endmodule

bind eewr_ctrl eewr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .on_boundary(on_boundary),
  .wp_n(wp_n), .status(status), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr), .ev_set_wel(ev_set_wel)
);

// File: tb/test_eewr_ctrl.sv
module test_eewr_ctrl;

  localparam int CYC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_write = 0, cmd_wrsr = 0;
  logic [11:0] addr_in = '0;
  logic byte_vld = 0;
  logic [7:0] byte_in = '0;
  logic cs_rise = 0, on_boundary = 1, wp_n = 1;
  logic [7:0] status;
  logic busy, mem_we;
  logic [11:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2 clk = ~clk;

  eewr_ctrl #(.ADDR_W(12), .PAGE_BYTES(32), .WRITE_CYCLES(CYC)) i_eewr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_write(cmd_write),
    .cmd_wrsr(cmd_wrsr), .addr_in(addr_in), .byte_vld(byte_vld), .byte_in(byte_in),
    .cs_rise(cs_rise), .on_boundary(on_boundary), .wp_n(wp_n), .status(status),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int compared = 0, mismatched = 0;
  string cur_req = "R8";
  bit finished = 0;

  // Behavioural reference model.
  int  m_mode;          // 0 idle, 1 wren, 2 data, 3 status, 4 spoiled
  bit  m_wel, m_wpen;
  int  m_bp;
  int  m_left, m_el;
  bit  m_page;
  int  m_base, m_off, m_srn;
  byte m_sr;
  byte m_buf [32];
  bit  m_have [32];

  function automatic bit guarded(int bp, int base);
    int lim;
    lim = (bp == 0) ? 4096 : 4096 - 1024 * (1 << (bp - 1));
    return base >= lim;
  endfunction

  function automatic bit any_have();
    foreach (m_have[i]) if (m_have[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_wel = 0; m_wpen = 0; m_bp = 0; m_left = 0; m_el = 0;
      m_page = 0; m_base = 0; m_off = 0; m_srn = 0; m_sr = 0;
      foreach (m_have[i]) begin m_have[i] = 0; m_buf[i] = 0; end
    end else begin
      bit was_busy;
      was_busy = (m_left > 0);
      if (was_busy) begin
        m_left--; m_el++;
        if (m_left == 0) m_wel = 0;
      end
      if (cs_rise) begin
        if (!was_busy && on_boundary) begin
          if (m_mode == 1) m_wel = 1;
          else if (m_mode == 2 && any_have() && m_wel) begin
            if (guarded(m_bp, m_base)) m_wel = 0;
            else begin m_left = CYC; m_el = 0; m_page = 1; end
          end else if (m_mode == 3 && m_srn == 1 && m_wel) begin
            if (m_wpen && !wp_n) m_wel = 0;
            else begin
              m_wpen = m_sr[7]; m_bp = m_sr[3:2];
              m_left = CYC; m_el = 0; m_page = 0;
            end
          end
        end
        m_mode = 0;
      end else if (cmd_wren || cmd_write || cmd_wrsr) begin
        if (m_mode != 0 || was_busy) m_mode = 4;
        else if (cmd_wren) m_mode = 1;
        else if (cmd_write) begin
          m_mode = 2; m_base = addr_in & 12'hFE0; m_off = addr_in % 32;
          foreach (m_have[i]) m_have[i] = 0;
        end else begin m_mode = 3; m_srn = 0; end
      end else if (byte_vld) begin
        if (m_mode == 1) m_mode = 4;
        else if (m_mode == 2) begin
          m_buf[m_off] = byte_in; m_have[m_off] = 1; m_off = (m_off + 1) % 32;
        end else if (m_mode == 3) begin
          if (m_srn == 0) begin m_sr = byte_in; m_srn = 1; end
          else m_mode = 4;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_busy, e_we;
      logic [7:0] e_st;
      e_busy = (m_left > 0);
      e_we = e_busy && m_page && m_el < 32 && m_have[m_el % 32];
      e_st = 8'(m_wpen) << 7 | 8'(m_bp) << 2 | 8'(m_wel) << 1 | 8'(e_busy);
      compared++;
      if (status !== e_st || busy !== e_busy || mem_we !== e_we ||
          (e_we && (mem_addr !== 12'(m_base + m_el) || mem_wdata !== m_buf[m_el]))) begin
        mismatched++;
        $display("FAIL %s t=%0t status=%h/%h busy=%b/%b we=%b/%b addr=%h/%h data=%h/%h",
                 cur_req, $time, status, e_st, busy, e_busy, mem_we, e_we,
                 mem_addr, 12'(m_base + m_el), mem_wdata, e_we ? m_buf[m_el] : 8'h00);
      end
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wren(); @(negedge clk); cmd_wren = 1; @(negedge clk); cmd_wren = 0; endtask
  task automatic wrcmd(logic [11:0] a);
    @(negedge clk); cmd_write = 1; addr_in = a; @(negedge clk); cmd_write = 0;
  endtask
  task automatic srcmd(); @(negedge clk); cmd_wrsr = 1; @(negedge clk); cmd_wrsr = 0; endtask
  task automatic sendb(logic [7:0] b);
    @(negedge clk); byte_vld = 1; byte_in = b; @(negedge clk); byte_vld = 0;
  endtask
  task automatic csup(bit bnd);
    @(negedge clk); cs_rise = 1; on_boundary = bnd; @(negedge clk); cs_rise = 0; on_boundary = 1;
  endtask
  task automatic drain(); while (busy) @(negedge clk); idle(2); endtask
  task automatic set_sr(logic [7:0] v);
    wren(); csup(1); srcmd(); sendb(v); csup(1); drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      finished = 1;
      $finish;
    end
  end

  initial begin
    idle(4); rst_n = 1; idle(3);                  // R8 reset state
    cur_req = "R1";
    wren(); csup(0); idle(2);                     // off boundary: no latch
    wren(); sendb(8'h11); csup(1); idle(2);       // extra byte: no latch
    cur_req = "R2";
    wren(); wrcmd(12'h123); sendb(8'h5A); csup(1); idle(3);
    cur_req = "R1";
    wren(); csup(1); idle(2);                     // proper: latch set
    cur_req = "R5";
    wrcmd(12'h123); sendb(8'hA5); csup(1); drain();
    cur_req = "R6"; idle(2);
    cur_req = "R3";
    wren(); csup(1); wrcmd(12'h07E);
    sendb(8'h01); sendb(8'h02); sendb(8'h03); csup(1); drain();
    wren(); csup(1); wrcmd(12'h040);
    for (int i = 0; i < 34; i++) sendb(8'(8'h40 + i));
    csup(1); drain();
    cur_req = "R4";
    wren(); csup(1); wrcmd(12'h200); sendb(8'hC1); sendb(8'hC2); csup(0); idle(2);
    wrcmd(12'h200); csup(1); idle(2);
    wrcmd(12'h205); sendb(8'hD1); sendb(8'hD2); csup(1);
    cur_req = "R7";
    idle(3); wren(); csup(1); srcmd(); sendb(8'h8C); csup(1);
    wrcmd(12'h300); sendb(8'hEE); csup(1); drain();
    cur_req = "R10";
    set_sr(8'h04);
    cur_req = "R9";
    wren(); csup(1); wrcmd(12'hC10); sendb(8'h77); csup(1); idle(2);
    wren(); csup(1); wrcmd(12'hBFF); sendb(8'h78); csup(1); drain();
    set_sr(8'h08);
    wren(); csup(1); wrcmd(12'h810); sendb(8'h79); csup(1); idle(2);
    wren(); csup(1); wrcmd(12'h7E0); sendb(8'h7A); csup(1); drain();
    set_sr(8'h0C);
    wren(); csup(1); wrcmd(12'h010); sendb(8'h7B); csup(1); idle(2);
    cur_req = "R10";
    set_sr(8'h84);
    wp_n = 0; wren(); csup(1); srcmd(); sendb(8'h00); csup(1); idle(3);
    wren(); csup(1); srcmd(); sendb(8'h00); sendb(8'h00); csup(1); idle(2);
    wp_n = 1; wren(); csup(1); srcmd(); sendb(8'h00); sendb(8'h00); csup(1); idle(2);
    srcmd(); sendb(8'h00); csup(1); drain();
    cur_req = "R9";
    wren(); csup(1); wrcmd(12'hFFF); sendb(8'h99); csup(1); drain();
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule